// File: doc/BRIEF.md
# Four-Lane Vector Register File with Element-Wise Adder

This block keeps eight vector registers, each made of 64 elements of 64 bits, and runs an integer add of two of them into a third. The storage and the arithmetic are cut into four lanes. Element `i` lives in lane `i mod 4`, at row `i div 4` of that lane's private slice. Because an element only ever combines with the element of the same index in the other register, each lane reads, adds and writes back its own rows without any routing between lanes.

An operation starts with a one-cycle start request that names two source registers and a destination register. The control then steps through the 16 rows, one row per clock in every lane at once, so four elements are issued per cycle. Each row passes an operand-read stage and an add stage before it is written back. Busy stays high for the whole run, and done pulses once when the last row has landed. A host port writes single elements while the block is idle, and a combinational peek port reads any element at any time.

Top module: `vlaneExec`

## Requirements
- R1: After reset, and whenever reset is asserted during an operation, `busyOut` and `doneOut` are both 0.
- R2: While idle, a host write with `hostWeIn`=1 stores `hostDataIn` into element `hostIdxIn` of register `hostRegIn` at the clock edge. `peekDataOut` shows element `peekIdxIn` of register `peekRegIn` combinationally, and no other element changes.
- R3: When an operation completes, every element i (0..63) of the destination register equals element i of the first source plus element i of the second source.
- R4: A start request made while idle is accepted at a clock edge, and `busyOut` is 1 from that edge onward. `doneOut` rises, and `busyOut` falls, exactly 18 edges later (16 issue cycles plus 2 pipeline stages). `doneOut` is high for exactly one cycle.
- R5: A start request made while busy is ignored. The running operation keeps its registers and its timing, and the register named as destination in the ignored request is not changed.
- R6: A host write made while busy is ignored, and the addressed element keeps its value.
- R7: When the destination equals one or both sources, the result is still the element-wise sum of the source values as they stood before the operation.
- R8: Addition wraps modulo 2^64, and the carry out of bit 63 is dropped.
- R9: An operation leaves every register other than its destination unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Request to begin an add operation |
| srcAIn | input | 3 | First source register index |
| srcBIn | input | 3 | Second source register index |
| dstIn | input | 3 | Destination register index |
| busyOut | output | 1 | An operation is in progress |
| doneOut | output | 1 | One-cycle pulse when the last element has been written |
| hostWeIn | input | 1 | Host element write enable |
| hostRegIn | input | 3 | Host write register index |
| hostIdxIn | input | 6 | Host write element index |
| hostDataIn | input | 64 | Host write data |
| peekRegIn | input | 3 | Peek register index |
| peekIdxIn | input | 6 | Peek element index |
| peekDataOut | output | 64 | Element value selected by the peek port |

## Verification
On every cycle, the assertions check the following: the done pulse lasts one cycle and coincides with busy falling; the row counter steps by one while issuing; the latched register indices hold still when a start arrives during a run; and no lane ever sees a host write competing with a pipeline write-back. Only the bench scenarios can show the arithmetic itself. These cover wrap-around sums, destination aliasing one or both sources, registers that should stay untouched, the exact 18-edge latency, and the ignored start and write under load, all compared against a software copy of the register contents.

// File: rtl/vlanePkg.sv
package vlanePkg;
  localparam int ELEM_W   = 64;
  localparam int VLEN     = 64;
  localparam int LANE_CNT = 4;
  localparam int VREG_CNT = 8;
  // Operand-read stage plus add stage inside each lane.
  localparam int PIPE_LAT = 2;

  localparam int ROW_CNT  = VLEN / LANE_CNT;
  localparam int ROW_W    = $clog2(ROW_CNT);
  localparam int LANE_W   = $clog2(LANE_CNT);
  localparam int REG_W    = $clog2(VREG_CNT);
  localparam int IDX_W    = $clog2(VLEN);
  localparam int SEQ_LEN  = ROW_CNT + PIPE_LAT;
  localparam int SEQ_W    = $clog2(SEQ_LEN + 1);

  typedef logic [ELEM_W-1:0] elemT;

  // Strobes from the sequencer to every lane.
  typedef struct packed {
    logic             issue;
    logic [ROW_W-1:0] row;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [REG_W-1:0] dst;
    logic             hostWrOk;
  } laneCmdT;
endpackage

// File: rtl/vlaneSlice.sv
module vlaneSlice
  import vlanePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCmdT          cmd,
  input  logic             hostWe,
  input  logic [REG_W-1:0] hostReg,
  input  logic [ROW_W-1:0] hostRow,
  input  elemT             hostData,
  input  logic [REG_W-1:0] peekReg,
  input  logic [ROW_W-1:0] peekRow,
  output elemT             peekData
);
  localparam int SLOTS = VREG_CNT * ROW_CNT;

  elemT store [SLOTS];

  logic             s1Valid, s2Valid;
  logic [ROW_W-1:0] s1Row, s2Row;
  logic [REG_W-1:0] s1Dst, s2Dst;
  elemT             opA, opB, sumQ;

  function automatic logic [REG_W+ROW_W-1:0] slotOf(input logic [REG_W-1:0] r,
                                                    input logic [ROW_W-1:0] w);
    return {r, w};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= cmd.issue;
      s2Valid <= s1Valid;
    end
  end

  // Row r is read two edges before it is written, and each row is
  // visited once, so a destination aliasing a source reads old data.
  always_ff @(posedge clk) begin
    if (cmd.issue) begin
      opA   <= store[slotOf(cmd.srcA, cmd.row)];
      opB   <= store[slotOf(cmd.srcB, cmd.row)];
      s1Row <= cmd.row;
      s1Dst <= cmd.dst;
    end
    if (s1Valid) begin
      sumQ  <= opA + opB;
      s2Row <= s1Row;
      s2Dst <= s1Dst;
    end
    if (s2Valid)
      store[slotOf(s2Dst, s2Row)] <= sumQ;
    else if (hostWe && cmd.hostWrOk)
      store[slotOf(hostReg, hostRow)] <= hostData;
  end

  assign peekData = store[slotOf(peekReg, peekRow)];

  // R6: the host path is never enabled while a write-back is in flight.
  p_no_host_clash_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(s2Valid && cmd.hostWrOk));
endmodule

// File: rtl/vlaneDatapath.sv
module vlaneDatapath
  import vlanePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCmdT          cmd,
  input  logic             hostWe,
  input  logic [REG_W-1:0] hostReg,
  input  logic [IDX_W-1:0] hostIdx,
  input  elemT             hostData,
  input  logic [REG_W-1:0] peekReg,
  input  logic [IDX_W-1:0] peekIdx,
  output elemT             peekData
);
  elemT lanePeek [LANE_CNT];

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic laneWe;
    assign laneWe = hostWe && (hostIdx[LANE_W-1:0] == LANE_W'(g));

    vlaneSlice uSlice (
      .clk      (clk),
      .rstN     (rstN),
      .cmd      (cmd),
      .hostWe   (laneWe),
      .hostReg  (hostReg),
      .hostRow  (hostIdx[IDX_W-1:LANE_W]),
      .hostData (hostData),
      .peekReg  (peekReg),
      .peekRow  (peekIdx[IDX_W-1:LANE_W]),
      .peekData (lanePeek[g])
    );
  end

  assign peekData = lanePeek[peekIdx[LANE_W-1:0]];
endmodule

// File: rtl/vlaneCtrl.sv
module vlaneCtrl
  import vlanePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [REG_W-1:0] srcAIn,
  input  logic [REG_W-1:0] srcBIn,
  input  logic [REG_W-1:0] dstIn,
  output laneCmdT          cmd,
  output logic             busyOut,
  output logic             doneOut
);
  localparam logic [SEQ_W-1:0] LAST_STEP = SEQ_W'(SEQ_LEN - 1);
  localparam logic [SEQ_W-1:0] ISSUE_END = SEQ_W'(ROW_CNT);
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROW_CNT - 1);

  logic             busyQ, doneQ;
  logic [SEQ_W-1:0] stepQ;
  logic [REG_W-1:0] srcAQ, srcBQ, dstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      stepQ <= '0;
      srcAQ <= '0;
      srcBQ <= '0;
      dstQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (startIn) begin
          busyQ <= 1'b1;
          stepQ <= '0;
          srcAQ <= srcAIn;
          srcBQ <= srcBIn;
          dstQ  <= dstIn;
        end
      end else begin
        stepQ <= stepQ + 1'b1;
        if (stepQ == LAST_STEP) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd.issue    = busyQ && (stepQ < ISSUE_END);
    cmd.row      = stepQ[ROW_W-1:0];
    cmd.srcA     = srcAQ;
    cmd.srcB     = srcBQ;
    cmd.dst      = dstQ;
    cmd.hostWrOk = !busyQ;
  end

  assign busyOut = busyQ;
  assign doneOut = doneQ;

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> doneOut);

  p_row_steps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.issue && cmd.row != LAST_ROW) |=>
      (cmd.issue && cmd.row == $past(cmd.row) + 1'b1));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn) |=> ($stable(dstQ) && $stable(srcAQ) && $stable(srcBQ)));
endmodule

// File: rtl/vlaneExec.sv
module vlaneExec
  import vlanePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [REG_W-1:0] srcAIn,
  input  logic [REG_W-1:0] srcBIn,
  input  logic [REG_W-1:0] dstIn,
  output logic             busyOut,
  output logic             doneOut,
  input  logic             hostWeIn,
  input  logic [REG_W-1:0] hostRegIn,
  input  logic [IDX_W-1:0] hostIdxIn,
  input  elemT             hostDataIn,
  input  logic [REG_W-1:0] peekRegIn,
  input  logic [IDX_W-1:0] peekIdxIn,
  output elemT             peekDataOut
);
  laneCmdT cmd;

  vlaneCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .srcAIn  (srcAIn),
    .srcBIn  (srcBIn),
    .dstIn   (dstIn),
    .cmd     (cmd),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  vlaneDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .hostWe   (hostWeIn),
    .hostReg  (hostRegIn),
    .hostIdx  (hostIdxIn),
    .hostData (hostDataIn),
    .peekReg  (peekRegIn),
    .peekIdx  (peekIdxIn),
    .peekData (peekDataOut)
  );
endmodule

// File: tb/test_vlaneExec.sv
`timescale 1ns/1ps
module test_vlaneExec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [2:0]  srcAIn = '0, srcBIn = '0, dstIn = '0;
  logic        busyOut, doneOut;
  logic        hostWeIn = 1'b0;
  logic [2:0]  hostRegIn = '0;
  logic [5:0]  hostIdxIn = '0;
  logic [63:0] hostDataIn = '0;
  logic [2:0]  peekRegIn = '0;
  logic [5:0]  peekIdxIn = '0;
  logic [63:0] peekDataOut;

  int errCnt = 0;
  int chkCnt = 0;
  logic [63:0] shadow [8][64];

  always #4 clk = ~clk;

  vlaneExec i_vlaneExec (
    .clk(clk), .rstN(rstN), .startIn(startIn), .srcAIn(srcAIn), .srcBIn(srcBIn),
    .dstIn(dstIn), .busyOut(busyOut), .doneOut(doneOut), .hostWeIn(hostWeIn),
    .hostRegIn(hostRegIn), .hostIdxIn(hostIdxIn), .hostDataIn(hostDataIn),
    .peekRegIn(peekRegIn), .peekIdxIn(peekIdxIn), .peekDataOut(peekDataOut)
  );

  // fields: srcA[136:134] srcB[133:131] dst[130:128] seedA[127:64] seedB[63:0]
  localparam logic [136:0] VECTORS [5] = '{
    {3'd1, 3'd2, 3'd3, 64'h0000_0000_0000_1000, 64'h0000_0000_0002_0000},
    {3'd3, 3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_0000_0100},
    {3'd4, 3'd2, 3'd5, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_F0F0_F0F0},
    {3'd5, 3'd6, 3'd5, 64'h8000_0000_0000_0000, 64'h7FFF_0000_1111_2222},
    {3'd7, 3'd7, 3'd7, 64'hC000_0000_0000_0001, 64'h0000_0000_0000_0000}
  };

  function automatic logic [63:0] pat(input logic [63:0] seed, input int i);
    return seed + 64'(i) * 64'h0001_0000_0001_0003;
  endfunction

  function automatic string vecTag(input int n);
    case (n)
      1:       return "R8";
      3, 4:    return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeElem(input int r, input int i, input logic [63:0] d);
    @(negedge clk);
    hostWeIn = 1'b1; hostRegIn = 3'(r); hostIdxIn = 6'(i); hostDataIn = d;
    @(negedge clk);
    hostWeIn = 1'b0;
    shadow[r][i] = d;
  endtask

  task automatic readElem(input int r, input int i, output logic [63:0] d);
    @(negedge clk);
    peekRegIn = 3'(r); peekIdxIn = 6'(i);
    #1 d = peekDataOut;
  endtask

  task automatic sweep(input int d, input string dTag, input int x1, input string t1,
                       input int x2, input string t2);
    for (int r = 0; r < 8; r++) begin
      string tag;
      tag = (r == d) ? dTag : (r == x1) ? t1 : (r == x2) ? t2 : "R9";
      for (int i = 0; i < 64; i++) begin
        logic [63:0] v;
        readElem(r, i, v);
        chk(tag, $sformatf("reg %0d elem %0d", r, i), v, shadow[r][i]);
      end
    end
  endtask

  // Runs one add, checks timing (R4), optionally injects an ignored
  // start (R5) and an ignored host write (R6), then updates the shadow.
  task automatic runOp(input int a, input int b, input int d, input bit poke);
    int bad = 0;
    logic [63:0] sums [64];
    @(negedge clk);
    srcAIn = 3'(a); srcBIn = 3'(b); dstIn = 3'(d); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    if (busyOut !== 1'b1 || doneOut !== 1'b0) bad++;
    for (int k = 2; k <= 20; k++) begin
      @(negedge clk);
      if (k <= 18 && (busyOut !== 1'b1 || doneOut !== 1'b0)) bad++;
      if (k == 19 && (busyOut !== 1'b0 || doneOut !== 1'b1)) bad++;
      if (k == 20 && (busyOut !== 1'b0 || doneOut !== 1'b0)) bad++;
      if (poke) begin
        if (k == 5) begin srcAIn = 3'd4; srcBIn = 3'd4; dstIn = 3'd6; startIn = 1'b1; end
        if (k == 6) startIn = 1'b0;
        if (k == 7) begin
          hostWeIn = 1'b1; hostRegIn = 3'd0; hostIdxIn = 6'd9;
          hostDataIn = 64'hDEAD_BEEF_0BAD_F00D;
        end
        if (k == 8) hostWeIn = 1'b0;
      end
    end
    chk("R4", $sformatf("busy/done timing op %0d+%0d->%0d", a, b, d), 64'(bad), 64'd0);
    for (int i = 0; i < 64; i++) sums[i] = shadow[a][i] + shadow[b][i];
    for (int i = 0; i < 64; i++) shadow[d][i] = sums[i];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 64'(busyOut), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 64'(busyOut), 64'd0);
    chk("R1", "done after reset", 64'(doneOut), 64'd0);

    // Load every register with a known pattern.
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++)
        writeElem(r, i, pat(64'h0100_0000_0000_0000 * 64'(r + 1), i));

    // R2: element write lands and its neighbours stay put.
    writeElem(6, 63, 64'hA5A5_0000_FFFF_1234);
    readElem(6, 63, v); chk("R2", "elem 63 readback", v, 64'hA5A5_0000_FFFF_1234);
    readElem(6, 62, v); chk("R2", "elem 62 untouched", v, shadow[6][62]);
    writeElem(6, 0, 64'h0000_0000_0000_0042);
    readElem(6, 0, v);  chk("R2", "elem 0 readback", v, 64'h42);
    readElem(6, 1, v);  chk("R2", "elem 1 untouched", v, shadow[6][1]);

    // Table walk: reload sources, add, sweep all registers.
    for (int n = 0; n < 5; n++) begin
      int a, b, d;
      a = int'(VECTORS[n][136:134]);
      b = int'(VECTORS[n][133:131]);
      d = int'(VECTORS[n][130:128]);
      for (int i = 0; i < 64; i++) writeElem(a, i, pat(VECTORS[n][127:64], i));
      for (int i = 0; i < 64; i++) writeElem(b, i, pat(VECTORS[n][63:0], i));
      runOp(a, b, d, 1'b0);
      sweep(d, vecTag(n), -1, "", -1, "");
    end

    // R8 directed: all-ones plus one wraps to zero.
    writeElem(1, 17, 64'hFFFF_FFFF_FFFF_FFFF);
    writeElem(2, 17, 64'h1);
    runOp(1, 2, 3, 1'b0);
    readElem(3, 17, v); chk("R8", "carry dropped", v, 64'h0);

    // R5 and R6: start and host write during a run are ignored.
    runOp(1, 2, 3, 1'b1);
    sweep(3, "R3", 6, "R5", 0, "R6");

    // R1: reset in the middle of a run, then recovery.
    @(negedge clk);
    srcAIn = 3'd1; srcBIn = 3'd2; dstIn = 3'd7; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (6) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1", "busy under mid-run reset", 64'(busyOut), 64'd0);
    chk("R1", "done under mid-run reset", 64'(doneOut), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (busyOut !== 1'b0 || doneOut !== 1'b0) begin
        chk("R1", "idle after mid-run reset", {62'd0, busyOut, doneOut}, 64'd0);
        break;
      end
    end
    runOp(1, 2, 7, 1'b0);
    sweep(7, "R3", -1, "", -1, "");

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule